// File: doc/BRIEF.md
# Mode-Banked General Register File

This block stores the sixteen 32-bit general registers of a processor core and makes each handler mode see its own copies of some of them. A register read or write names an architectural register (0 to 15) and the current processor mode. A small combinational mapper turns that pair into a 5-bit physical row of a 31-entry array. An exception or interrupt handler therefore works in its own stack pointer and link register. The fast-interrupt handler also has its own registers 8 to 12, so none of these need to be saved and restored on entry or exit.

There are two read ports and one write port, and all three share the mode input. Read data is registered, so it appears one cycle after the address. When a port reads the physical row that is being written in the same cycle, it returns the new data (write-first). The array has no reset, so it can map to block RAM. Only the output registers are cleared by the synchronous reset.

Top module: `bankreg_file`

## Requirements
- R1: While `rst` is high at a rising edge, both read outputs become zero at that edge.
- R2: Registers 0 to 7 and register 15 are one physical copy each, shared by every mode: a value written in any mode is read back in any other mode.
- R3: Mode codes are 0 user/system, 1 fast interrupt, 2 interrupt, 3 supervisor, 4 abort, 5 undefined. Codes 6 and 7 behave exactly like code 0.
- R4: In mode 1, registers 8 to 14 are private copies. Writes to them in mode 1 do not change what other modes read, and writes from other modes do not change what mode 1 reads.
- R5: In modes 2 to 5, registers 13 and 14 are private copies. Registers 8 to 12 in these modes are the same copies that user mode sees.
- R6: The six copies of register 13 (user, modes 1 to 5) are all distinct, and so are the six copies of register 14.
- R7: Read data is registered: an address presented before a rising edge is reflected on the output only after that edge, and the output holds its old value until then.
- R8: When a write and a read address the same physical row in the same cycle, the read output after that edge is the data being written.
- R9: The two read ports are independent. When both address the same register they return the same value.
- R10: A write takes effect at the rising edge where `we` is high, and a read in any later cycle returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the read output registers |
| mode | input | 3 | Current processor mode code |
| ra_idx | input | 4 | Architectural register number, read port A |
| rb_idx | input | 4 | Architectural register number, read port B |
| we | input | 1 | Write enable |
| wr_idx | input | 4 | Architectural register number for the write |
| wr_data | input | 32 | Write data |
| ra_data | output | 32 | Registered read data, port A |
| rb_data | output | 32 | Registered read data, port B |

## Verification
Each read result is due one edge after its address is applied. The bench drives inputs on the falling edge and samples on the next falling edge, so exactly one rising edge lies between stimulus and check. Writes issued in one cycle are checked through reads that are set up on the falling edge after that write. The bypass case drives the write and the read in the same cycle and expects the new value after the single edge. The latency check samples just before that edge and expects the old value.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;
  localparam int ARCH_N = 16;
  localparam int ARCH_W = $clog2(ARCH_N);
  localparam int FIQ_N  = 7;
  localparam int EXC_MODES = 4;
  localparam int PHYS_N = ARCH_N + FIQ_N + 2 * EXC_MODES;
  localparam int PHYS_W = $clog2(PHYS_N);

  typedef enum logic [2:0] {
    MODE_USR = 3'd0,
    MODE_FIQ = 3'd1,
    MODE_IRQ = 3'd2,
    MODE_SVC = 3'd3,
    MODE_ABT = 3'd4,
    MODE_UND = 3'd5
  } cpu_mode_e;

  localparam logic [ARCH_W-1:0] FIQ_LO = ARCH_W'(8);
  localparam logic [ARCH_W-1:0] FIQ_HI = ARCH_W'(14);
  localparam logic [ARCH_W-1:0] SP_IDX = ARCH_W'(13);
  localparam logic [ARCH_W-1:0] LR_IDX = ARCH_W'(14);
  localparam logic [PHYS_W-1:0] FIQ_BASE = PHYS_W'(ARCH_N);
  localparam logic [PHYS_W-1:0] EXC_BASE = PHYS_W'(ARCH_N + FIQ_N);
endpackage

// File: rtl/bankreg_map.sv
module bankreg_map
  import bankreg_pkg::*;
(
  input  logic [2:0]        mode,
  input  logic [ARCH_W-1:0] arch_idx,
  output logic [PHYS_W-1:0] phys_idx
);
  logic [PHYS_W-1:0] bank_off;
  logic              is_spl;

  assign is_spl   = (arch_idx == SP_IDX) || (arch_idx == LR_IDX);
  assign bank_off = PHYS_W'({mode - 3'd2, 1'b0});

  always_comb begin
    phys_idx = PHYS_W'(arch_idx);
    case (mode)
      MODE_FIQ: begin
        if (arch_idx >= FIQ_LO && arch_idx <= FIQ_HI)
          phys_idx = FIQ_BASE + PHYS_W'(arch_idx - FIQ_LO);
      end
      MODE_IRQ, MODE_SVC, MODE_ABT, MODE_UND: begin
        if (is_spl)
          phys_idx = EXC_BASE + bank_off + PHYS_W'(arch_idx == LR_IDX);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bankreg_store.sv
module bankreg_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 31,
  parameter int NRD    = 2,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [AW-1:0]             wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic [NRD-1:0][AW-1:0]    rd_addr,
  output logic [NRD-1:0][DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wr_addr] <= wr_data;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_ff @(posedge clk) begin
      if (rst)
        rd_data[p] <= '0;
      else if (we && (wr_addr == rd_addr[p]))
        rd_data[p] <= wr_data;
      else
        rd_data[p] <= mem[rd_addr[p]];
    end
  end
endmodule

// File: rtl/bankreg_file.sv
module bankreg_file
  import bankreg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        mode,
  input  logic [ARCH_W-1:0] ra_idx,
  input  logic [ARCH_W-1:0] rb_idx,
  input  logic              we,
  input  logic [ARCH_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] ra_data,
  output logic [DATA_W-1:0] rb_data
);
  localparam int NRD = 2;

  logic [NRD-1:0][ARCH_W-1:0] rd_arch;
  logic [NRD-1:0][PHYS_W-1:0] rd_phys;
  logic [NRD-1:0][DATA_W-1:0] rd_q;
  logic [PHYS_W-1:0]          wr_phys;

  assign rd_arch = {rb_idx, ra_idx};

  for (genvar p = 0; p < NRD; p++) begin : g_map
    bankreg_map u_rmap (
      .mode     (mode),
      .arch_idx (rd_arch[p]),
      .phys_idx (rd_phys[p])
    );
  end

  bankreg_map u_wmap (
    .mode     (mode),
    .arch_idx (wr_idx),
    .phys_idx (wr_phys)
  );

  bankreg_store #(
    .DATA_W (DATA_W),
    .DEPTH  (PHYS_N),
    .NRD    (NRD)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .we      (we),
    .wr_addr (wr_phys),
    .wr_data (wr_data),
    .rd_addr (rd_phys),
    .rd_data (rd_q)
  );

  assign ra_data = rd_q[0];
  assign rb_data = rd_q[1];
endmodule

// File: rtl/bankreg_file_chk.sv
module bankreg_file_chk
  import bankreg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        mode,
  input logic [ARCH_W-1:0] ra_idx,
  input logic [ARCH_W-1:0] rb_idx,
  input logic              we,
  input logic [ARCH_W-1:0] wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] ra_data,
  input logic [DATA_W-1:0] rb_data
);
  // R1: reset clears both outputs
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (ra_data == '0 && rb_data == '0));

  // R8: same register written and read in one cycle returns new data
  a_r8_write_first: assert property (@(posedge clk) disable iff (rst)
    (we && wr_idx == ra_idx) |=> (ra_data == $past(wr_data)));

  // R9: both ports agree on the same register
  a_r9_ports_agree: assert property (@(posedge clk) disable iff (rst)
    (ra_idx == rb_idx) |=> (ra_data == rb_data));

  // R2: low registers are shared, whatever mode reads them back
  a_r2_low_shared: assert property (@(posedge clk) disable iff (rst)
    (!we && $past(we) && $past(wr_idx) < ARCH_W'(8) && ra_idx == $past(wr_idx))
    |=> (ra_data == $past(wr_data, 2)));
endmodule

bind bankreg_file bankreg_file_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/bankreg_file_tb_top.sv
module bankreg_file_tb_top;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    mode = 3'd0;
  logic [3:0]    ra_idx = '0, rb_idx = '0, wr_idx = '0;
  logic          we = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] ra_data, rb_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  bankreg_file #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .mode(mode), .ra_idx(ra_idx), .rb_idx(rb_idx),
    .we(we), .wr_idx(wr_idx), .wr_data(wr_data),
    .ra_data(ra_data), .rb_data(rb_data)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] m, input logic [3:0] i, input logic [DW-1:0] d);
    @(negedge clk);
    mode = m; wr_idx = i; wr_data = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  // addresses applied now, sampled one edge later
  task automatic rchk(input string req, input logic [2:0] m, input logic [3:0] i, input logic [DW-1:0] exp);
    mode = m; ra_idx = i; rb_idx = i;
    @(negedge clk);
    check({req, " portA"}, ra_data, exp);
    check({req, " portB"}, rb_data, exp);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset A", ra_data, '0);
    check("R1 reset B", rb_data, '0);
    rst = 1'b0;
  endtask

  task automatic t_shared;
    wreg(3'd1, 4'd3, 32'h0303_0001);
    rchk("R2 r3 usr", 3'd0, 4'd3, 32'h0303_0001);
    rchk("R2 r3 irq", 3'd2, 4'd3, 32'h0303_0001);
    rchk("R10 r3 und", 3'd5, 4'd3, 32'h0303_0001);
    wreg(3'd3, 4'd15, 32'h0F0F_0003);
    rchk("R2 r15 usr", 3'd0, 4'd15, 32'h0F0F_0003);
    rchk("R2 r15 fiq", 3'd1, 4'd15, 32'h0F0F_0003);
  endtask

  task automatic t_fiq;
    for (int r = 8; r <= 14; r++) begin
      wreg(3'd0, 4'(r), 32'hA000_0000 + 32'(r));
      wreg(3'd1, 4'(r), 32'hF000_0000 + 32'(r));
    end
    for (int r = 8; r <= 14; r++) begin
      rchk("R4 fiq copy", 3'd1, 4'(r), 32'hF000_0000 + 32'(r));
      rchk("R4 user copy", 3'd0, 4'(r), 32'hA000_0000 + 32'(r));
    end
  endtask

  task automatic t_exc;
    for (int m = 2; m <= 5; m++) begin
      wreg(3'(m), 4'd13, 32'h5D00_0000 + 32'(m));
      wreg(3'(m), 4'd14, 32'h1E00_0000 + 32'(m));
    end
    for (int m = 2; m <= 5; m++) begin
      rchk("R6 sp bank", 3'(m), 4'd13, 32'h5D00_0000 + 32'(m));
      rchk("R6 lr bank", 3'(m), 4'd14, 32'h1E00_0000 + 32'(m));
    end
    rchk("R6 user sp", 3'd0, 4'd13, 32'hA000_000D);
    rchk("R6 fiq lr", 3'd1, 4'd14, 32'hF000_000E);
    wreg(3'd2, 4'd10, 32'h0A0A_0002);
    rchk("R5 r10 irq to usr", 3'd0, 4'd10, 32'h0A0A_0002);
    rchk("R5 r12 usr in svc", 3'd3, 4'd12, 32'hA000_000C);
    rchk("R4 fiq r10 untouched", 3'd1, 4'd10, 32'hF000_000A);
  endtask

  task automatic t_unsup;
    rchk("R3 mode6 sp", 3'd6, 4'd13, 32'hA000_000D);
    wreg(3'd7, 4'd14, 32'h7777_0014);
    rchk("R3 mode7 lr seen by usr", 3'd0, 4'd14, 32'h7777_0014);
    rchk("R3 irq lr kept", 3'd2, 4'd14, 32'h1E00_0002);
  endtask

  task automatic t_bypass;
    @(negedge clk);
    mode = 3'd4; wr_idx = 4'd13; wr_data = 32'hB0B0_0004; we = 1'b1;
    ra_idx = 4'd13; rb_idx = 4'd2;
    @(negedge clk);
    we = 1'b0;
    check("R8 bypass A", ra_data, 32'hB0B0_0004);
    rchk("R8 stored", 3'd4, 4'd13, 32'hB0B0_0004);
    rchk("R8 other bank intact", 3'd5, 4'd13, 32'h5D00_0005);
  endtask

  task automatic t_dual;
    wreg(3'd0, 4'd5, 32'h0000_5555);
    wreg(3'd0, 4'd6, 32'h0000_6666);
    mode = 3'd0; ra_idx = 4'd5; rb_idx = 4'd6;
    @(negedge clk);
    check("R9 port A", ra_data, 32'h0000_5555);
    check("R9 port B", rb_data, 32'h0000_6666);
    ra_idx = 4'd6; rb_idx = 4'd5;
    @(posedge clk);
    #1;
    @(negedge clk);
    check("R9 swap A", ra_data, 32'h0000_6666);
    check("R9 swap B", rb_data, 32'h0000_5555);
    ra_idx = 4'd5;
    #5;
    check("R7 holds before edge", ra_data, 32'h0000_6666);
    @(negedge clk);
    check("R7 updates after edge", ra_data, 32'h0000_5555);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_shared();
    t_fiq();
    t_exc();
    t_unsup();
    t_bypass();
    t_dual();
    t_reset();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule